// File: doc/BRIEF.md
# Two-Group Prioritised Interrupt Controller

This block collects fifteen interrupt lines, numbered 1 to 15, and turns them into a single 4-bit interrupt request for processor 0. Software controls it through a 256-byte window of aligned 32-bit registers. The window holds:

- a shared pending word;
- a priority-group word, which splits the sources into a high group and a low group;
- a word that routes lines to processor force registers instead of pending;
- banks of per-processor mask, force and extended words, one word per processor in each bank, for up to 16 processors.

A rising edge on a line records an event. The event lands either in the shared pending word or, for routed lines, in every processor's force word. The request looks only at processor 0's mask and force words. Among the active sources, any member of the high group beats every member of the low group. Within the winning group, the highest line number is reported. An acknowledge input carrying an interrupt number retires that source.

The register port is a plain single-cycle port. A write takes effect at the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`. The port has no handshake and no back-pressure: every access completes in the cycle it is presented. The acknowledge is a one-cycle strobe and is never stalled. Address bits 1:0 are ignored.

Top module: `irqc_top`

## Requirements
- R1: After reset every register reads zero and `cpu_irq` is 0.
- R2: Bit 0 is never an interrupt. Writes to the group, routing, mask, force (both the bank and the alias) and clear words drop bit 0. A rising edge on `irq_lines[0]` records nothing.
- R3: The active set is (pending OR processor-0 force) AND processor-0 mask. Whenever any active bit has its group bit (group word at offset 0x00) at 1, the request comes from those bits only. Otherwise it comes from the remaining active bits.
- R4: `cpu_irq` carries the highest-numbered bit of the winning group, or 0 when nothing is active. It reflects the register state one clock after that state changes.
- R5: Writing the clear word (0x0C) removes the written bits 15:1 from both the pending word (0x04) and processor 0's force word.
- R6: An `ack_valid` strobe with number n clears bit n of pending and of processor 0's force word. Other processors' force words are left unchanged.
- R7: A write to the force bank word of processor p (0x80 + 4p) sets the bits given in data bits 15:1. It clears the line bits given in data bits 31:17, where data bit 16+n clears line n. The result is (old OR set) AND NOT clear. A read returns the new value. Mask words sit at 0x40 + 4p.
- R8: A write to the alias word (0x08) replaces processor 0's force word with data bits 15:1. The alias reads back the same value as 0x80.
- R9: A rising edge on line n whose routing bit (word 0x14) is 1 sets bit n in every processor's force word and leaves pending untouched. A line whose routing bit is 0 sets pending bit n.
- R10: A line held high records only one event. When an event and a clear (write or acknowledge) for the same bit occur in the same cycle, the bit ends up clear.
- R11: The status word (0x10) reads zero and ignores writes. Extended words (0xC0 + 4p) keep only data bits 3:0 and do not affect the request. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| irq_lines | input | 16 | Interrupt lines; bit 0 unused |
| bus_we | input | 1 | Write strobe for the word at `bus_addr` |
| bus_addr | input | 8 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_num | input | 4 | Interrupt number being acknowledged |
| cpu_irq | output | 4 | Request level for processor 0, 0 when idle |

## Verification
Register reads are due in the cycle after the write edge. A line pulse, acknowledge or clear shows in pending or force one edge after it is presented. `cpu_irq` lags that state by one further edge, so it is due two edges after the stimulus. Every step of the bench drives its inputs on the falling edge. Reads are compared just after that edge, against the state left by earlier steps. A request check is placed only after at least one idle step has followed the last state change.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Global word indices (byte offset / 4); the bank is picked by address bits 7:6
  localparam logic [5:0] W_GROUP  = 6'h00;
  localparam logic [5:0] W_PEND   = 6'h01;
  localparam logic [5:0] W_ALIAS  = 6'h02;
  localparam logic [5:0] W_CLEAR  = 6'h03;
  localparam logic [5:0] W_STATUS = 6'h04;
  localparam logic [5:0] W_ROUTE  = 6'h05;

  typedef enum logic [1:0] {
    BANK_GLOBAL = 2'b00,
    BANK_MASK   = 2'b01,
    BANK_FORCE  = 2'b10,
    BANK_EXT    = 2'b11
  } bank_e;

  localparam int unsigned EXT_W = 4;
  localparam int unsigned SEL_W = 4;  // processor index within a 16-word bank
endpackage

// File: rtl/irqc_edge_det.sv
module irqc_edge_det #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines;
  end

  assign evt = lines & ~prev_q;

  // R10: an event never appears on two consecutive edges for the same line
  p_single_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & $past(evt)) == '0));
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int unsigned W     = 16,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 1; i < int'(W); i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  always_comb begin
    // R4: the reported index is a member of the vector, and no higher bit is set
    p_enc_member_r4: assert ((vec[W-1:1] == '0) || vec[idx]);
    p_enc_highest_r4: assert (((vec >> idx) >> 1) == '0);
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_CPU   = 16,
  parameter int NUM_LINES = 15,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_LINES:0]                irq_lines,
  input  logic                              bus_we,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [DATA_W-1:0]                 bus_wdata,
  output logic [DATA_W-1:0]                 bus_rdata,
  input  logic                              ack_valid,
  input  logic [$clog2(NUM_LINES+1)-1:0]    ack_num,
  output logic [$clog2(NUM_LINES+1)-1:0]    cpu_irq
);
  localparam int IW    = NUM_LINES + 1;
  localparam int IDX_W = $clog2(IW);
  localparam int HALF  = DATA_W / 2;
  localparam logic [IW-1:0] NO_B0 = {{(IW-1){1'b1}}, 1'b0};

  // ---------------- decode ----------------
  logic [5:0]       word;
  bank_e            bank;
  logic [SEL_W-1:0] cpu_sel;
  logic             cpu_ok;
  logic [IW-1:0]    w_set, w_clr, kill;

  assign word    = bus_addr[7:2];
  assign bank    = bank_e'(bus_addr[7:6]);
  assign cpu_sel = bus_addr[5:2];
  assign cpu_ok  = int'(cpu_sel) < NUM_CPU;
  assign w_set   = bus_wdata[IW-1:0] & NO_B0;
  assign w_clr   = bus_wdata[HALF+IW-1:HALF] & NO_B0;

  logic wr_group, wr_clear, wr_alias, wr_route;
  assign wr_group = bus_we && bank == BANK_GLOBAL && word == W_GROUP;
  assign wr_alias = bus_we && bank == BANK_GLOBAL && word == W_ALIAS;
  assign wr_clear = bus_we && bank == BANK_GLOBAL && word == W_CLEAR;
  assign wr_route = bus_we && bank == BANK_GLOBAL && word == W_ROUTE;

  // bits retired this cycle by a clear write or an acknowledge
  assign kill = ((wr_clear ? w_set : '0) |
                 (ack_valid ? (IW'(1) << ack_num) : '0)) & NO_B0;

  // ---------------- line events ----------------
  logic [IW-1:0] evt_raw, evt;

  irqc_edge_det #(.W(IW)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lines (irq_lines),
    .evt   (evt_raw)
  );
  assign evt = evt_raw & NO_B0;

  // ---------------- global words ----------------
  logic [IW-1:0] group_q, route_q, pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      group_q <= '0;
      route_q <= '0;
      pend_q  <= '0;
    end else begin
      if (wr_group) group_q <= w_set;
      if (wr_route) route_q <= w_set;
      pend_q <= (pend_q | (evt & ~route_q)) & ~kill;
    end
  end

  // ---------------- per-processor banks ----------------
  logic [IW-1:0]    msk_arr [NUM_CPU];
  logic [IW-1:0]    frc_arr [NUM_CPU];
  logic [EXT_W-1:0] ext_arr [NUM_CPU];

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic             hit;
    logic [IW-1:0]    msk_q, frc_q, frc_nx;
    logic [EXT_W-1:0] ext_q;

    assign hit = bus_we && cpu_sel == SEL_W'(c);

    always_comb begin
      frc_nx = frc_q;
      if (hit && bank == BANK_FORCE) frc_nx = (frc_nx | w_set) & ~w_clr;
      if (c == 0 && wr_alias)        frc_nx = w_set;
      frc_nx = frc_nx | (evt & route_q);
      if (c == 0)                    frc_nx = frc_nx & ~kill;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        msk_q <= '0;
        frc_q <= '0;
        ext_q <= '0;
      end else begin
        frc_q <= frc_nx;
        if (hit && bank == BANK_MASK) msk_q <= w_set;
        if (hit && bank == BANK_EXT)  ext_q <= bus_wdata[EXT_W-1:0];
      end
    end

    assign msk_arr[c] = msk_q;
    assign frc_arr[c] = frc_q;
    assign ext_arr[c] = ext_q;
  end

  // ---------------- request ----------------
  logic [IW-1:0]    act, hi_grp, lo_grp, win;
  logic [IDX_W-1:0] win_idx;

  assign act    = (pend_q | frc_arr[0]) & msk_arr[0];
  assign hi_grp = act & group_q;
  assign lo_grp = act & ~group_q;
  assign win    = (hi_grp != '0) ? hi_grp : lo_grp;

  irqc_prio_enc #(.W(IW), .IDX_W(IDX_W)) u_enc (
    .vec (win),
    .idx (win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_irq <= '0;
    else        cpu_irq <= win_idx;
  end

  // ---------------- read path ----------------
  always_comb begin
    bus_rdata = '0;
    unique case (bank)
      BANK_GLOBAL: begin
        case (word)
          W_GROUP: bus_rdata[IW-1:0] = group_q;
          W_PEND:  bus_rdata[IW-1:0] = pend_q;
          W_ALIAS: bus_rdata[IW-1:0] = frc_arr[0];
          W_ROUTE: bus_rdata[IW-1:0] = route_q;
          default: ;
        endcase
      end
      BANK_MASK:  if (cpu_ok) bus_rdata[IW-1:0]    = msk_arr[cpu_sel];
      BANK_FORCE: if (cpu_ok) bus_rdata[IW-1:0]    = frc_arr[cpu_sel];
      BANK_EXT:   if (cpu_ok) bus_rdata[EXT_W-1:0] = ext_arr[cpu_sel];
      default: ;
    endcase
  end

  // ---------------- assertions ----------------
  // R2: no bit-0 state in the shared words or in processor 0's force word
  p_bit0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] == 1'b0 && group_q[0] == 1'b0 && route_q[0] == 1'b0 &&
     frc_arr[0][0] == 1'b0));

  // R5: bits named in a clear write are gone from pending after the edge
  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear |=> ((pend_q & $past(w_set)) == '0));

  // R6: an acknowledged number is absent from pending and processor-0 force
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_num != '0) |=>
      (pend_q[$past(ack_num)] == 1'b0 && frc_arr[0][$past(ack_num)] == 1'b0));

  // R9: a line routed to the force words never raises a pending bit
  p_route_no_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & $past(route_q)) == '0));

  // R11: the status word always reads zero
  p_status_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bank == BANK_GLOBAL && word == W_STATUS) |-> (bus_rdata == '0));

  // R4: with nothing active the request drops to zero on the next edge
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |=> (cpu_irq == '0));
endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
  localparam int K_NOP = 0, K_WR = 1, K_RD = 2, K_IRQ = 3, K_OUT = 4;

  typedef struct packed {
    logic [2:0]  kind;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VECS [NV] = '{
    '{3'(K_RD),  8'h00, 32'h0,         32'h0,     "R1"},
    '{3'(K_RD),  8'h04, 32'h0,         32'h0,     "R1"},
    '{3'(K_OUT), 8'h00, 32'h0,         32'h0,     "R1"},
    '{3'(K_WR),  8'h40, 32'hFFFF_FFFF, 32'h0,     "R2"},
    '{3'(K_RD),  8'h40, 32'h0,         32'hFFFE,  "R2"},
    '{3'(K_IRQ), 8'h00, 32'h0028,      32'h0,     "R9"},
    '{3'(K_NOP), 8'h00, 32'h0,         32'h0,     "R4"},
    '{3'(K_OUT), 8'h00, 32'h0,         32'd5,     "R4"},
    '{3'(K_RD),  8'h04, 32'h0,         32'h0028,  "R9"},
    '{3'(K_WR),  8'h00, 32'h0009,      32'h0,     "R3"},
    '{3'(K_NOP), 8'h00, 32'h0,         32'h0,     "R3"},
    '{3'(K_OUT), 8'h00, 32'h0,         32'd3,     "R3"},
    '{3'(K_RD),  8'h00, 32'h0,         32'h0008,  "R2"},
    '{3'(K_WR),  8'h0C, 32'h0009,      32'h0,     "R5"},
    '{3'(K_NOP), 8'h00, 32'h0,         32'h0,     "R5"},
    '{3'(K_OUT), 8'h00, 32'h0,         32'd5,     "R5"},
    '{3'(K_RD),  8'h04, 32'h0,         32'h0020,  "R5"},
    '{3'(K_WR),  8'h08, 32'h0003,      32'h0,     "R8"},
    '{3'(K_RD),  8'h08, 32'h0,         32'h0002,  "R8"},
    '{3'(K_WR),  8'h80, 32'h0002_0010, 32'h0,     "R7"},
    '{3'(K_RD),  8'h80, 32'h0,         32'h0010,  "R7"},
    '{3'(K_RD),  8'h08, 32'h0,         32'h0010,  "R8"},
    '{3'(K_WR),  8'h00, 32'h0010,      32'h0,     "R3"},
    '{3'(K_NOP), 8'h00, 32'h0,         32'h0,     "R3"},
    '{3'(K_OUT), 8'h00, 32'h0,         32'd4,     "R3"},
    '{3'(K_WR),  8'h84, 32'h0100,      32'h0,     "R7"},
    '{3'(K_RD),  8'h84, 32'h0,         32'h0100,  "R7"},
    '{3'(K_OUT), 8'h00, 32'h0,         32'd4,     "R7"},
    '{3'(K_WR),  8'h14, 32'h0041,      32'h0,     "R9"},
    '{3'(K_RD),  8'h14, 32'h0,         32'h0040,  "R9"},
    '{3'(K_IRQ), 8'h00, 32'h0040,      32'h0,     "R9"},
    '{3'(K_RD),  8'h04, 32'h0,         32'h0020,  "R9"},
    '{3'(K_RD),  8'h84, 32'h0,         32'h0140,  "R9"},
    '{3'(K_RD),  8'h08, 32'h0,         32'h0050,  "R9"},
    '{3'(K_OUT), 8'h00, 32'h0,         32'd4,     "R3"},
    '{3'(K_WR),  8'h10, 32'hFFFF,      32'h0,     "R11"},
    '{3'(K_RD),  8'h10, 32'h0,         32'h0,     "R11"},
    '{3'(K_WR),  8'hC0, 32'hFFFF_FFFF, 32'h0,     "R11"},
    '{3'(K_RD),  8'hC0, 32'h0,         32'h000F,  "R11"},
    '{3'(K_RD),  8'h20, 32'h0,         32'h0,     "R11"},
    '{3'(K_WR),  8'h40, 32'h0040,      32'h0,     "R3"},
    '{3'(K_NOP), 8'h00, 32'h0,         32'h0,     "R3"},
    '{3'(K_OUT), 8'h00, 32'h0,         32'd6,     "R3"},
    '{3'(K_WR),  8'h40, 32'h0,         32'h0,     "R4"},
    '{3'(K_NOP), 8'h00, 32'h0,         32'h0,     "R4"},
    '{3'(K_OUT), 8'h00, 32'h0,         32'd0,     "R4"}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_num = '0;
  logic [3:0]  cpu_irq;
  logic [15:0] hold = '0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irqc_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ack_valid (ack_valid),
    .ack_num   (ack_num),
    .cpu_irq   (cpu_irq)
  );

  task automatic drive(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic [15:0] pulse, input logic av, input logic [3:0] an);
    @(negedge clk);
    bus_we    = we;
    bus_addr  = a;
    bus_wdata = d;
    irq_lines = hold | pulse;
    ack_valid = av;
    ack_num   = an;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1'b1, a, d, '0, 1'b0, '0);
  endtask

  task automatic nop();
    drive(1'b0, '0, '0, '0, 1'b0, '0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    drive(1'b0, a, '0, '0, 1'b0, '0);
    #1 check(tag, $sformatf("read 0x%0h", a), bus_rdata, exp);
  endtask

  task automatic out(input logic [3:0] exp, input string tag);
    nop();
    #1 check(tag, "cpu_irq", {28'h0, cpu_irq}, {28'h0, exp});
  endtask

  task automatic ack(input logic [3:0] n);
    drive(1'b0, '0, '0, '0, 1'b1, n);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (int'(VECS[i].kind))
        K_WR:  wr(VECS[i].addr, VECS[i].data);
        K_RD:  rd(VECS[i].addr, VECS[i].exp, $sformatf("%s", VECS[i].tag));
        K_IRQ: drive(1'b0, '0, '0, VECS[i].data[15:0], 1'b0, '0);
        K_OUT: out(VECS[i].exp[3:0], $sformatf("%s", VECS[i].tag));
        default: nop();
      endcase
    end

    // R6: acknowledge retires processor-0 bits only
    wr(8'h40, 32'hFFFE);
    ack(4'd6);
    rd(8'h08, 32'h0010, "R6");
    rd(8'h84, 32'h0140, "R6");
    ack(4'd5);
    rd(8'h04, 32'h0000, "R6");
    ack(4'd4);
    nop();
    out(4'd0, "R6");

    // R2: line 0 and bit 0 of the alias are dropped
    drive(1'b0, '0, '0, 16'h0001, 1'b0, '0);
    rd(8'h04, 32'h0, "R2");
    wr(8'h08, 32'hFFFF);
    rd(8'h08, 32'hFFFE, "R2");
    wr(8'h08, 32'h0);

    // R10: a held line gives one event; clear beats a same-cycle event
    hold = 16'h0080;
    nop(); nop(); nop();
    rd(8'h04, 32'h0080, "R10");
    wr(8'h0C, 32'h0080);
    nop(); nop();
    rd(8'h04, 32'h0000, "R10");
    hold = '0;
    nop();
    hold = 16'h0080;
    wr(8'h0C, 32'h0080);
    nop();
    rd(8'h04, 32'h0000, "R10");
    hold = '0;
    nop();

    // R1: reset in mid-run returns every word to zero
    rst_n = 1'b0;
    nop(); nop();
    rst_n = 1'b1;
    rd(8'h00, 32'h0, "R1");
    rd(8'h40, 32'h0, "R1");
    rd(8'h84, 32'h0, "R1");
    rd(8'h14, 32'h0, "R1");
    rd(8'hC0, 32'h0, "R1");
    out(4'd0, "R1");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung run, expected completion");
      summary();
      $finish;
    end
  end
endmodule